// File: doc/BRIEF.md
# Test-Cube Hold-Flag Classifier

This block encodes a scan test cube as it streams in, one position per clock, before the seeds are solved. Each input position is a care/value pair: care low marks an unspecified (don't-care) position. The stream is cut into fixed blocks of `BLK_LEN` accepted positions. For every block the classifier emits a two-bit hold flag, coded as {care, value}. Transition blocks get `10` and must be loaded from the pattern generator. Held blocks get `11` and repeat the last scan value. Blocks with no specified position get `00`. The flag depends on the block's own specified bits and on the most recent specified bit of earlier blocks in the same cube.

The cube is also passed on as an encoded care/value stream, delayed by exactly one block. The delay lets the block go back to the final position of the previous block. When that position is unspecified, and fixing it removes the transition at the current block, it is specified to the current block's polarity. A running counter gives the number of bits the seed solver must still satisfy: specified flags, plus the care bits of transition blocks, plus the positions specified by conversion.

A new cube starts with a position that has `cube_first_i` set. That position clears the history, the block position and the counter. The encoded stream runs continuously across cubes, so the final block of a cube leaves the delay line while the next cube is accepted.

Top module: `hold_flag_enc`

## Requirements
- R1: `flag_vld_o` is high for exactly one cycle, in the cycle after the accepting edge of the `BLK_LEN`-th position of a block. A position with `cube_first_i` set is position 0 of a new block, and any partial block before it gets no flag.
- R2: A block that holds both a specified 0 and a specified 1 is flagged `10` (transition).
- R3: A block whose specified bits all have one polarity, opposite to the latest earlier specified bit of the cube, is flagged `10` when conversion (R7) is not allowed. Conversion is not allowed when the previous block's last position is specified or the previous block was not flagged `10`.
- R4: A single-polarity block that matches the latest earlier specified bit of the cube is flagged `11` (hold).
- R5: A block with no specified position is flagged `00`, and it leaves the cube's history unchanged.
- R6: A single-polarity block with no earlier specified bit in the cube is flagged `11`.
- R7: Conversion applies to a single-polarity block opposite to the history whose previous block in the same cube was flagged `10` and ended in an unspecified position. Such a block is flagged `11`, and that previous position is emitted with care 1 and value equal to the block's polarity.
- R8: Each accepted position is emitted on `data_*_o` in the cycle after the accepting edge of the position `BLK_LEN` accepts later, and it is unchanged apart from R7. The first `BLK_LEN` positions accepted after reset emit nothing.
- R9: `spec_cnt_o` is cleared by a `cube_first_i` position. One cycle after each block ends, it has grown by 1 for a specified flag, plus the block's care count when flagged `10`, plus 1 for a conversion.
- R10: History and conversion never cross a cube boundary. The first specified block of a cube follows R6 whatever the previous cube held.
- R11: Cycles with `bit_vld_i` low change no output and no state.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Input position present this cycle |
| bit_care_i | input | 1 | Position is specified |
| bit_val_i | input | 1 | Position value (meaningful when specified) |
| cube_first_i | input | 1 | Position is the first of a new cube |
| flag_vld_o | output | 1 | Hold flag for the block just completed |
| flag_o | output | 2 | Hold flag {care, value}: 10 transition, 11 hold, 00 unspecified |
| data_vld_o | output | 1 | Encoded position present |
| data_care_o | output | 1 | Encoded position is specified |
| data_val_o | output | 1 | Encoded position value |
| spec_cnt_o | output | CNT_W | Specified flags plus specified data bits in the current cube |

## Verification
Cubes are built so that each flag outcome arises from one clear cause. A block with mixed polarity tells R2 apart from the history rules. Single-polarity blocks are preceded by matching, opposite, empty or absent history, which separates R3, R4, R5 and R6. Conversion is tried with a transition block ending in an unspecified position, and it is refused when that position is specified or when the previous block was held. Each case therefore shows in both the flag and the rewritten position. A back-to-back pair of cubes and a mid-block restart check that nothing leaks over a cube boundary. A cube repeated with an idle cycle after every position must give identical flags, data and count.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

  typedef enum logic [1:0] {
    FLG_DC  = 2'b00,
    FLG_TRN = 2'b10,
    FLG_HLD = 2'b11
  } flag_e;

  typedef struct packed {
    logic care;
    logic val;
  } tbit_t;

endpackage

// File: rtl/hfc_delay_line.sv
module hfc_delay_line
  import hfc_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  tbit_t din_i,
  output tbit_t dout_o,
  output logic  full_o
);

  localparam int unsigned FW = $clog2(DEPTH + 1);

  tbit_t          stage_q [DEPTH];
  logic [FW-1:0]  fill_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
      end else if (push_i) begin
        if (g == 0) stage_q[g] <= din_i;
        else        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                fill_q <= '0;
    else if (push_i && (fill_q != FW'(DEPTH)))  fill_q <= fill_q + 1'b1;
  end

  assign dout_o = stage_q[DEPTH-1];
  assign full_o = (fill_q == FW'(DEPTH));

endmodule

// File: rtl/hfc_block_stats.sv
module hfc_block_stats
  import hfc_pkg::*;
#(
  parameter int unsigned BLK_LEN = 4,
  localparam int unsigned NC_W   = $clog2(BLK_LEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            restart_i,
  input  tbit_t           cur_i,
  output logic            end_o,
  output logic            any0_o,
  output logic            any1_o,
  output logic            last_val_o,
  output logic [NC_W-1:0] ncare_o
);

  localparam int unsigned PW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;

  logic [PW-1:0]   pos_q, pos_e;
  logic            s0_q, s1_q, lv_q;
  logic            s0_e, s1_e, lv_e;
  logic [NC_W-1:0] nc_q, nc_e;

  // restart treats the current position as index 0 of an empty block
  always_comb begin
    pos_e = restart_i ? '0   : pos_q;
    s0_e  = restart_i ? 1'b0 : s0_q;
    s1_e  = restart_i ? 1'b0 : s1_q;
    lv_e  = restart_i ? 1'b0 : lv_q;
    nc_e  = restart_i ? '0   : nc_q;
  end

  assign any0_o     = s0_e | (cur_i.care & ~cur_i.val);
  assign any1_o     = s1_e | (cur_i.care &  cur_i.val);
  assign last_val_o = cur_i.care ? cur_i.val : lv_e;
  assign ncare_o    = nc_e + NC_W'(cur_i.care);
  assign end_o      = (pos_e == PW'(BLK_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      s0_q  <= 1'b0;
      s1_q  <= 1'b0;
      lv_q  <= 1'b0;
      nc_q  <= '0;
    end else if (push_i) begin
      if (end_o) begin
        pos_q <= '0;
        s0_q  <= 1'b0;
        s1_q  <= 1'b0;
        lv_q  <= 1'b0;
        nc_q  <= '0;
      end else begin
        pos_q <= pos_e + 1'b1;
        s0_q  <= any0_o;
        s1_q  <= any1_o;
        lv_q  <= last_val_o;
        nc_q  <= ncare_o;
      end
    end
  end

endmodule

// File: rtl/hfc_classifier.sv
module hfc_classifier
  import hfc_pkg::*;
#(
  parameter int unsigned NC_W  = 3,
  parameter int unsigned CNT_W = 12
) (
  input  logic             any0_i,
  input  logic             any1_i,
  input  logic             hist_vld_i,
  input  logic             hist_val_i,
  input  logic             prev_trn_i,
  input  logic             tail_care_i,
  input  logic [NC_W-1:0]  ncare_i,
  output flag_e            code_o,
  output logic             convert_o,
  output logic             pol_o,
  output logic [CNT_W-1:0] contrib_o
);

  assign pol_o = any1_i;

  always_comb begin
    convert_o = 1'b0;
    if (!any0_i && !any1_i)                 code_o = FLG_DC;
    else if (any0_i && any1_i)              code_o = FLG_TRN;
    else if (!hist_vld_i || (hist_val_i == pol_o)) code_o = FLG_HLD;
    else if (prev_trn_i && !tail_care_i) begin
      // fix the previous block's trailing X to remove the edge
      code_o    = FLG_HLD;
      convert_o = 1'b1;
    end else                                code_o = FLG_TRN;
  end

  always_comb begin
    contrib_o = '0;
    if (code_o != FLG_DC)  contrib_o = contrib_o + 1'b1;
    if (code_o == FLG_TRN) contrib_o = contrib_o + CNT_W'(ncare_i);
    if (convert_o)         contrib_o = contrib_o + 1'b1;
  end

endmodule

// File: rtl/hold_flag_enc.sv
module hold_flag_enc
  import hfc_pkg::*;
#(
  parameter int unsigned BLK_LEN = 4,
  parameter int unsigned CNT_W   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_care_i,
  input  logic             bit_val_i,
  input  logic             cube_first_i,
  output logic             flag_vld_o,
  output logic [1:0]       flag_o,
  output logic             data_vld_o,
  output logic             data_care_o,
  output logic             data_val_o,
  output logic [CNT_W-1:0] spec_cnt_o
);

  localparam int unsigned NC_W = $clog2(BLK_LEN + 1);

  tbit_t           cur, tail;
  logic            full;
  logic            blk_end, any0, any1, last_val;
  logic [NC_W-1:0] ncare;
  flag_e           code;
  logic            convert, conv_eff, pol;
  logic [CNT_W-1:0] contrib;

  logic            hist_vld_q, hist_val_q, prev_trn_q;
  logic            hv_e, hval_e, pt_e;
  logic [CNT_W-1:0] cnt_base, cnt_nxt;

  assign cur.care = bit_care_i;
  assign cur.val  = bit_val_i;

  hfc_delay_line #(.DEPTH(BLK_LEN)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (bit_vld_i),
    .din_i  (cur),
    .dout_o (tail),
    .full_o (full)
  );

  hfc_block_stats #(.BLK_LEN(BLK_LEN)) u_stats (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (bit_vld_i),
    .restart_i  (cube_first_i),
    .cur_i      (cur),
    .end_o      (blk_end),
    .any0_o     (any0),
    .any1_o     (any1),
    .last_val_o (last_val),
    .ncare_o    (ncare)
  );

  // cube boundary wipes history before the current position is judged
  always_comb begin
    hv_e   = cube_first_i ? 1'b0 : hist_vld_q;
    hval_e = cube_first_i ? 1'b0 : hist_val_q;
    pt_e   = cube_first_i ? 1'b0 : prev_trn_q;
  end

  hfc_classifier #(.NC_W(NC_W), .CNT_W(CNT_W)) u_cls (
    .any0_i      (any0),
    .any1_i      (any1),
    .hist_vld_i  (hv_e),
    .hist_val_i  (hval_e),
    .prev_trn_i  (pt_e),
    .tail_care_i (tail.care),
    .ncare_i     (ncare),
    .code_o      (code),
    .convert_o   (convert),
    .pol_o       (pol),
    .contrib_o   (contrib)
  );

  assign conv_eff = blk_end & convert;
  assign cnt_base = cube_first_i ? '0 : spec_cnt_o;
  assign cnt_nxt  = cnt_base + (blk_end ? contrib : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_vld_q <= 1'b0;
      hist_val_q <= 1'b0;
      prev_trn_q <= 1'b0;
    end else if (bit_vld_i) begin
      if (blk_end) begin
        hist_vld_q <= hv_e | any0 | any1;
        hist_val_q <= (any0 | any1) ? last_val : hval_e;
        prev_trn_q <= (code == FLG_TRN);
      end else begin
        hist_vld_q <= hv_e;
        hist_val_q <= hval_e;
        prev_trn_q <= pt_e;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_vld_o  <= 1'b0;
      flag_o      <= FLG_DC;
      data_vld_o  <= 1'b0;
      data_care_o <= 1'b0;
      data_val_o  <= 1'b0;
      spec_cnt_o  <= '0;
    end else begin
      flag_vld_o <= bit_vld_i & blk_end;
      data_vld_o <= bit_vld_i & full;
      if (bit_vld_i) begin
        if (blk_end) flag_o <= code;
        data_care_o <= tail.care | conv_eff;
        data_val_o  <= conv_eff ? pol : tail.val;
        spec_cnt_o  <= cnt_nxt;
      end
    end
  end

endmodule

// File: rtl/hfc_chk.sv
module hfc_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_vld_i,
  input logic             bit_care_i,
  input logic             cube_first_i,
  input logic             flag_vld_o,
  input logic [1:0]       flag_o,
  input logic             data_vld_o,
  input logic [CNT_W-1:0] spec_cnt_o
);

  AST_FLAG_AFTER_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_vld_o |-> $past(bit_vld_i)); // R1

  AST_FLAG_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_vld_o |-> (flag_o != 2'b01)); // R5

  AST_DATA_AFTER_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> $past(bit_vld_i)); // R8

  AST_IDLE_CNT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(spec_cnt_o)); // R11

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && cube_first_i && !bit_care_i) |=> (spec_cnt_o == '0)); // R9

  AST_CNT_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && !cube_first_i) |=> (spec_cnt_o >= $past(spec_cnt_o))); // R9

endmodule

bind hold_flag_enc hfc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_vld_i    (bit_vld_i),
  .bit_care_i   (bit_care_i),
  .cube_first_i (cube_first_i),
  .flag_vld_o   (flag_vld_o),
  .flag_o       (flag_o),
  .data_vld_o   (data_vld_o),
  .spec_cnt_o   (spec_cnt_o)
);

// File: tb/sim_hold_flag_enc.sv
`timescale 1ns/1ps
module sim_hold_flag_enc;

  localparam int unsigned BLK_LEN = 4;
  localparam int unsigned CNT_W   = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_vld = 1'b0, bit_care = 1'b0, bit_val = 1'b0, cube_first = 1'b0;
  logic             flag_vld, data_vld, data_care, data_val;
  logic [1:0]       flag;
  logic [CNT_W-1:0] spec_cnt;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  string flags_got = "";
  string data_got  = "";

  always #2 clk = ~clk;

  hold_flag_enc #(.BLK_LEN(BLK_LEN), .CNT_W(CNT_W)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bit_vld_i    (bit_vld),
    .bit_care_i   (bit_care),
    .bit_val_i    (bit_val),
    .cube_first_i (cube_first),
    .flag_vld_o   (flag_vld),
    .flag_o       (flag),
    .data_vld_o   (data_vld),
    .data_care_o  (data_care),
    .data_val_o   (data_val),
    .spec_cnt_o   (spec_cnt)
  );

  // T = transition (10), H = hold (11), X = unspecified (00)
  always @(negedge clk) begin
    if (rst_n) begin
      if (flag_vld)
        flags_got = $sformatf("%s%s", flags_got,
          (flag == 2'b10) ? "T" : (flag == 2'b11) ? "H" : (flag == 2'b00) ? "X" : "?");
      if (data_vld)
        data_got = $sformatf("%s%s", data_got,
          !data_care ? "X" : (data_val ? "1" : "0"));
    end
  end

  task automatic chk_str(string req, string got, string exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got=%s exp=%s", req, got, exp);
    end
  endtask

  task automatic chk_int(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic put(logic c, logic v, logic f, bit gap);
    @(negedge clk);
    bit_vld = 1'b1; bit_care = c; bit_val = v; cube_first = f;
    @(posedge clk);
    if (gap) begin
      @(negedge clk);
      bit_vld = 1'b0; cube_first = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic send_cube(string s, bit gap);
    for (int i = 0; i < s.len(); i++)
      put(s[i] != "X", s[i] == "1", i == 0, gap);
    @(negedge clk);
    bit_vld = 1'b0; cube_first = 1'b0; bit_care = 1'b0; bit_val = 1'b0;
  endtask

  // cube, then count check, then a blank cube to drain the delay line
  task automatic run_cube(string tag, string cube, bit gap, string exp_flags,
                          string exp_data, int exp_cnt);
    flags_got = ""; data_got = "";
    send_cube(cube, gap);
    chk_int({tag, " count"}, int'(spec_cnt), exp_cnt);
    send_cube("XXXX", 1'b0);
    @(posedge clk); @(negedge clk);
    chk_str({tag, " flags"}, flags_got, {exp_flags, "X"});
    chk_str({tag, " data"}, data_got, exp_data);
  endtask

  task automatic t_reset();
    chk_int("R1 reset flag_vld", int'(flag_vld), 0);
    chk_int("R8 reset data_vld", int'(data_vld), 0);
    chk_int("R9 reset count", int'(spec_cnt), 0);
  endtask

  // R2 R4 R5 R8: mixed block, held blocks, empty block; nothing out for first block
  task automatic t_basic();
    run_cube("R2_R4_R5_R8 basic", "0XX1X1111XXXXXXX", 1'b0, "THHX",
             "0XX1X1111XXXXXXX", 5);
  endtask

  // R7: two conversions rewrite trailing X of the transition blocks
  task automatic t_convert();
    run_cube("R7 convert", "X01X0X0XXX1X0XXX", 1'b0, "THTH",
             {"XXXX", "X0100X0XXX100XXX"}, 9);
  endtask

  // R3: refused with specified tail, refused after held block
  task automatic t_no_convert();
    run_cube("R3 no convert", "01X10XXX0XXX1XXX", 1'b0, "TTHT",
             {"XXXX", "01X10XXX0XXX1XXX"}, 9);
  endtask

  // R6 R5: first specified block without history, empty blocks keep history
  task automatic t_no_history();
    run_cube("R6 no history", "XXXXX1XXXXXX1XX1", 1'b0, "XHXH",
             {"XXXX", "XXXXX1XXXXXX1XX1"}, 2);
  endtask

  // R10: second cube starts with no history, no conversion across boundary
  task automatic t_boundary();
    flags_got = ""; data_got = "";
    send_cube("01XX", 1'b0);
    chk_int("R10 first cube count", int'(spec_cnt), 3);
    send_cube("0XXX", 1'b0);
    chk_int("R10 R9 count restart", int'(spec_cnt), 1);
    send_cube("XXXX", 1'b0);
    @(posedge clk); @(negedge clk);
    chk_str("R10 flags", flags_got, "THX");
    chk_str("R10 data", data_got, "XXXX01XX0XXX");
  endtask

  // R11: idle cycle after every position changes nothing
  task automatic t_idle();
    run_cube("R11 idle gaps", "0XX1X1111XXXXXXX", 1'b1, "THHX",
             {"XXXX", "0XX1X1111XXXXXXX"}, 5);
  endtask

  // R1: restart in mid block drops the partial block's flag
  task automatic t_restart();
    flags_got = "";
    send_cube("01", 1'b0);
    chk_str("R1 partial block no flag", flags_got, "");
    send_cube("1X0X", 1'b0);
    @(posedge clk); @(negedge clk);
    chk_str("R1 restart flags", flags_got, "T");
    chk_int("R1 restart count", int'(spec_cnt), 3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_convert();
    t_no_convert();
    t_no_history();
    t_boundary();
    t_idle();
    t_restart();
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog got=timeout exp=done");
    finish_run();
  end

endmodule